// File: doc/BRIEF.md
# Complement-Method Carry-Select Adder

This block adds two N-bit unsigned operands and a carry in. The result is an N-bit sum and a carry out. The operands are cut into K-bit slices. Each slice holds only one ripple adder, and that adder assumes a slice carry in of zero. The result for a slice carry in of one is not computed by a second ripple adder. It is derived from the zero-carry sum: adding one to a number flips every bit up to and including its lowest zero bit.

A prefix chain inside each slice runs from the least significant bit upward. It records whether a zero has yet appeared among the lower zero-carry sum bits. Where no zero has appeared, the plus-one sum bit is the complement of the zero-carry bit. Otherwise the bit passes through unchanged. The lowest bit always flips, so it needs no select. The plus-one carry out is set when the zero-carry carry out is set or when every zero-carry sum bit is one. Multiplexers then choose between the two results using the carry that arrives from the slice below. The slices are chained to form the full width.

The block is purely combinational. It is used wherever a wide add is needed with a short carry path per slice.

Top module: `csel_cm_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `cin_i`) modulo 2^N, and `cout_o` equals bit N of that full sum. This holds for every input combination.
- R2: Inside each slice, the zero-carry ripple result, taken as a (K+1)-bit value with its carry out on top, equals the slice's `a` bits plus its `b` bits.
- R3: Select node i of a slice is 0 when every zero-carry sum bit below bit i is one, and 1 otherwise.
- R4: Bit 0 of a slice's plus-one sum is always the complement of bit 0 of its zero-carry sum.
- R5: A slice's plus-one result, taken as a (K+1)-bit value {carry, sum}, equals its zero-carry result plus one.
- R6: When a slice's incoming carry is 0, that slice drives its zero-carry sum and carry. When the incoming carry is 1, it drives the plus-one sum and carry.
- R7: The carry can travel the full width. For example, with `a_i` = all ones, `b_i` = 0 and `cin_i` = 1, the result is `sum_o` = 0 and `cout_o` = 1. Any operand pair whose bits pairwise sum to one behaves the same way.
- R8: At the value extremes the results are exact. Zero operands with `cin_i` = 1 give a sum of 1. All-ones operands with `cin_i` = 1 give an all-ones sum and `cout_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry into the least significant slice |
| sum_o | output | N | Sum modulo 2^N |
| cout_o | output | 1 | Carry out of the most significant slice |

## Verification
The bench goes after operands whose bit pairs all sum to one, with carry in set. A slice that derived its plus-one carry from the ripple carry alone, or whose prefix chain stopped early, would drop the carry and return a non-zero sum. Operands that make a slice's zero-carry sum exactly all ones, fed by a carry from below, expose an all-ones detect that never reaches the carry out. Such a fault leaves the upper slices one short. Single-slice increments with a zero at a chosen position show any off-by-one in the select chain as a wrong bit just above that zero. Random operands with both carry-in values catch a swapped output multiplexer.

// File: rtl/csel_cm_pkg.sv
package csel_cm_pkg;
  localparam int unsigned CSEL_DEF_WIDTH = 64;
  localparam int unsigned CSEL_DEF_SLICE = 8;
endpackage

// File: rtl/csel_ripple0.sv
// Ripple adder with its carry in tied to zero; also gives inverted sum bits.
module csel_ripple0 #(
  parameter int unsigned K = 8
) (
  input  logic [K-1:0] a_i,
  input  logic [K-1:0] b_i,
  output logic [K-1:0] s0_o,
  output logic [K-1:0] s0_n_o,
  output logic         co0_o
);
  logic [K:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < K; i++) begin : g_fa
    assign s0_o[i]      = a_i[i] ^ b_i[i] ^ carry[i];
    assign carry[i+1]   = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
  end

  assign s0_n_o = ~s0_o;
  assign co0_o  = carry[K];

  always_comb begin
    // R2
    ripple_sum_chk: assert ({co0_o, s0_o} == ((K+1)'(a_i) + (K+1)'(b_i)))
      else $error("R2 ripple sum mismatch");
  end
endmodule

// File: rtl/csel_zero_chain.sv
// Prefix chain: a node stays 0 while no zero sum bit has been seen below it.
module csel_zero_chain #(
  parameter int unsigned K = 8
) (
  input  logic [K-1:0] s0_i,
  output logic [K-1:1] sel_o,
  output logic         zseen_o
);
  logic [K:0] node;
  assign node[0] = 1'b0;

  for (genvar i = 0; i < K; i++) begin : g_node
    assign node[i+1] = node[i] | ~s0_i[i];
  end

  assign sel_o   = node[K-1:1];
  assign zseen_o = node[K];

  for (genvar i = 1; i < K; i++) begin : g_chk
    always_comb begin
      // R3
      zero_seen_chk: assert (sel_o[i] == ~(&s0_i[i-1:0]))
        else $error("R3 select node %0d wrong", i);
    end
  end
endmodule

// File: rtl/csel_cm_slice.sv
// One K-bit slice: single ripple adder, plus-one result by complementing.
module csel_cm_slice #(
  parameter int unsigned K = 8
) (
  input  logic [K-1:0] a_i,
  input  logic [K-1:0] b_i,
  input  logic         cin_i,
  output logic [K-1:0] sum_o,
  output logic         cout_o
);
  logic [K-1:0] s0, s0_n, s1;
  logic [K-1:1] sel;
  logic         co0, co1, zseen;

  csel_ripple0 #(.K(K)) i_ripple (
    .a_i(a_i), .b_i(b_i), .s0_o(s0), .s0_n_o(s0_n), .co0_o(co0)
  );

  csel_zero_chain #(.K(K)) i_chain (
    .s0_i(s0), .sel_o(sel), .zseen_o(zseen)
  );

  // lowest bit always flips
  assign s1[0] = s0_n[0];
  for (genvar i = 1; i < K; i++) begin : g_s1
    assign s1[i] = sel[i] ? s0[i] : s0_n[i];
  end

  assign co1 = co0 | ~zseen;

  always_comb begin
    if (cin_i) begin
      sum_o  = s1;
      cout_o = co1;
    end else begin
      sum_o  = s0;
      cout_o = co0;
    end
  end

  always_comb begin
    // R4
    bit0_flip_chk: assert (s1[0] != s0[0])
      else $error("R4 bit 0 not complemented");
    // R5
    plus_one_chk: assert ({co1, s1} == ({co0, s0} + (K+1)'(1)))
      else $error("R5 plus-one result wrong");
    // R6
    out_sel_chk: assert (cin_i ? ({cout_o, sum_o} == {co1, s1})
                               : ({cout_o, sum_o} == {co0, s0}))
      else $error("R6 output select wrong");
  end
endmodule

// File: rtl/csel_cm_adder.sv
module csel_cm_adder
  import csel_cm_pkg::*;
#(
  parameter int unsigned N = CSEL_DEF_WIDTH,
  parameter int unsigned K = CSEL_DEF_SLICE
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  localparam int unsigned NSLICE = N / K;

  logic [NSLICE:0] carry;
  assign carry[0] = cin_i;

  for (genvar j = 0; j < NSLICE; j++) begin : g_slice
    csel_cm_slice #(.K(K)) i_slice (
      .a_i   (a_i[j*K +: K]),
      .b_i   (b_i[j*K +: K]),
      .cin_i (carry[j]),
      .sum_o (sum_o[j*K +: K]),
      .cout_o(carry[j+1])
    );
  end

  assign cout_o = carry[NSLICE];

  always_comb begin
    // R1
    full_sum_chk: assert ({cout_o, sum_o} == ((N+1)'(a_i) + (N+1)'(b_i) + (N+1)'(cin_i)))
      else $error("R1 full sum mismatch");
  end
endmodule

// File: tb/test_csel_cm_adder.sv
module test_csel_cm_adder;
  localparam int unsigned N = 64;
  localparam int unsigned K = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] a, b;
  logic cin;
  logic [N-1:0] sum;
  logic cout;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csel_cm_adder #(.N(N), .K(K)) i_csel_cm_adder (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  // drive after a rising edge, compare at the following falling edge
  task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y,
                       input logic c, input string req);
    logic [N:0] expv;
    @(posedge clk);
    a = x; b = y; cin = c;
    expv = {1'b0, x} + {1'b0, y} + {{N{1'b0}}, c};
    @(negedge clk);
    checks++;
    if ({cout, sum} !== expv) begin
      fails++;
      $display("FAIL %s: got cout=%0b sum=%h expected cout=%0b sum=%h",
               req, cout, sum, expv[N], expv[N-1:0]);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: idle state after reset, zero in gives zero out
    apply('0, '0, 1'b0, "R1 reset");
    // R7: every bit pair sums to one, carry in set
    apply({N{1'b1}}, '0, 1'b1, "R7 ripple all");
    apply({(N/2){2'b10}}, {(N/2){2'b01}}, 1'b1, "R7 alternating");
    apply({(N/4){4'hC}}, {(N/4){4'h3}}, 1'b1, "R7 pattern");
    apply({(N/2){2'b10}}, {(N/2){2'b01}}, 1'b0, "R6 no carry in");
    // R8: extremes
    apply('0, '0, 1'b1, "R8 zero plus one");
    apply({N{1'b1}}, {N{1'b1}}, 1'b1, "R8 max");
    apply({N{1'b1}}, {N{1'b1}}, 1'b0, "R8 max no cin");
    // R3/R4/R5: single slice incremented with a zero at each position
    for (int p = 0; p < K; p++) begin
      logic [N-1:0] x;
      x = {N{1'b1}} >> (N - K);
      x[p] = 1'b0;
      apply(x, '0, 1'b1, "R3 zero position");
    end
    apply(64'h0000_0000_0000_0001, '0, 1'b1, "R4 bit0 flip");
    // R5/R6: lower slice carries into an all-ones upper slice
    apply(64'h0000_0000_0000_FF80, 64'h0000_0000_0000_0080, 1'b0, "R5 all-ones slice");
    apply(64'h0000_0000_00FF_FFFF, '0, 1'b1, "R5 multi slice");
    // R2/R1: random operands, both carry values
    for (int n = 0; n < 400; n++) begin
      apply({$urandom, $urandom}, {$urandom, $urandom}, n[0], "R2 random");
    end
    done = 1'b1;
    summary();
  end
endmodule